// File: doc/BRIEF.md
# Digital Constant-Fraction Timing Discriminator

This block takes one event's worth of digitized samples and reports when the pulse arrived, in fractional sample units. The arrival time does not shift with pulse height. Each sample first has a programmable pedestal removed. The sample is then mirrored if the pulse is negative-going, so that every later stage only sees positive-going pulses. The block finds the largest corrected value in the window and sets a threshold equal to a programmable fraction of that peak. It then walks backward from the peak to the last sample on the rising side that lies at or below the threshold. The crossing is placed between that sample and its successor by linear interpolation. The reported time has an integer sample index and eight fractional bits. The peak value is reported with it as the amplitude.

Samples arrive on a valid/ready stream. A transfer happens on a clock edge where `in_valid` and `in_ready` are both high. `in_first` marks the first sample of an event and `in_last` marks the final one. `in_ready` is high while the block waits for an event or is collecting one. It goes low from the cycle after the event closes until the result has been taken. Results leave on a second valid/ready handshake. `out_valid`, once raised, stays high with unchanged data until `out_ready` is seen high on a clock edge. Nothing is dropped under back-pressure: the producer simply waits. The fraction, the pedestal and the polarity are captured with the start sample, so changing them mid-event has no effect.

Top module: `cfd_timing_top`

## Requirements
- R1: A corrected sample is `in_data - baseline` when `invert` is 0, or `baseline - in_data` when `invert` is 1. `out_amp` is the largest corrected value of the event.
- R2: The peak is the first sample holding the maximum corrected value. The threshold is floor(peak * `k_frac` / 256), where `k_frac` is an unsigned 8-bit value.
- R3: The crossing index is the highest index below the peak index whose corrected value is at or below the threshold. `out_time[13:8]` holds that index.
- R4: `out_time[7:0]` is floor((threshold - a) * 256 / (b - a)), where a is the sample at the crossing index and b is the sample after it. A sample exactly equal to the threshold gives a fraction of 0.
- R5: Scaling every corrected sample of a pulse by an integer factor leaves `out_time` unchanged, provided the threshold product divides exactly.
- R6: If the peak is at index 0, or the peak is not positive, the result has `out_hit` = 0 and `out_time` = 0, and `out_amp` still reports the peak. Otherwise `out_hit` = 1.
- R7: A sample accepted while no event is open and without `in_first` is discarded and affects no result.
- R8: An event closes on its 64th sample even when `in_last` is absent. Samples that follow without `in_first` are discarded.
- R9: `in_ready` is low whenever `out_valid` is high. `out_valid` and the result fields hold steady until `out_ready` is sampled high.
- R10: `k_frac`, `baseline` and `invert` are taken from the start sample's cycle. Changes later in the event are ignored.
- R11: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 12 | Signed raw sample |
| in_first | input | 1 | Sample opens an event |
| in_last | input | 1 | Sample closes an event |
| k_frac | input | 8 | Threshold fraction, in units of 1/256 |
| invert | input | 1 | 1 selects negative-going pulses |
| baseline | input | 12 | Signed pedestal subtracted from each sample |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | A crossing was found |
| out_time | output | 14 | Crossing time: index in bits 13:8, fraction in bits 7:0 |
| out_amp | output | 13 | Signed corrected peak value |

## Verification
The bench targets pulses with tied maxima. A design that kept the last copy of the maximum would start its backward search from the wrong place and report a later time. It also targets a sample exactly on the threshold, which must give a zero fraction; a strict comparison would step one sample too far back. Events with the peak in the first slot, events with no positive excursion and events longer than the window are covered. A block that read past its edges would report crossings that do not exist, or pull late samples into the peak. Other cases are scaled copies of one pulse, a negative pulse on a raised pedestal, configuration changes mid-event and a stalled consumer. A wrong polarity or scaling path shows up as a changed time, and a weak handshake as a lost or altered result.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAP,
    ST_THR,
    ST_SCAN,
    ST_DIV,
    ST_OUT
  } cfd_state_e;

endpackage

// File: rtl/cfd_window.sv
module cfd_window #(
  parameter int SAMPLE_W = 12,
  parameter int DEPTH    = 64,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW      = SAMPLE_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       wr_first,
  input  logic signed [SAMPLE_W-1:0] wr_sample,
  input  logic signed [SAMPLE_W-1:0] baseline,
  input  logic                       invert,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic signed [CW-1:0]       rd_data,
  output logic signed [CW-1:0]       peak,
  output logic [IDX_W-1:0]           peak_idx,
  output logic [IDX_W-1:0]           wr_pos
);

  logic signed [CW-1:0] corr;
  logic [IDX_W-1:0]     wr_addr;
  logic signed [CW-1:0] mem [DEPTH];

  // pedestal removal and polarity folding
  always_comb begin
    if (invert)
      corr = {baseline[SAMPLE_W-1], baseline} - {wr_sample[SAMPLE_W-1], wr_sample};
    else
      corr = {wr_sample[SAMPLE_W-1], wr_sample} - {baseline[SAMPLE_W-1], baseline};
  end

  assign wr_addr = wr_first ? '0 : wr_pos;
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= corr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pos   <= '0;
      peak     <= '0;
      peak_idx <= '0;
    end else if (wr_en) begin
      wr_pos <= wr_addr + IDX_W'(1);
      // strict compare keeps the earliest of equal maxima
      if (wr_first || corr > peak) begin
        peak     <= corr;
        peak_idx <= wr_addr;
      end
    end
  end

  // peak only grows while an event is being filled
  assert_peak_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_first |=> peak >= $past(peak));

endmodule

// File: rtl/cfd_frac_div.sv
module cfd_frac_div #(
  parameter int NW     = 14,
  parameter int FRAC_W = 8,
  localparam int CNT_W = $clog2(FRAC_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NW-1:0]     num,
  input  logic [NW-1:0]     den,
  output logic              busy,
  output logic              done,
  output logic [FRAC_W-1:0] quot
);

  logic [NW-1:0]    rem;
  logic [NW-1:0]    den_q;
  logic [NW:0]      shifted;
  logic [NW:0]      diff;
  logic [CNT_W-1:0] cnt;
  logic             take;

  assign shifted = {rem, 1'b0};
  assign diff    = shifted - {1'b0, den_q};
  assign take    = shifted >= {1'b0, den_q};

  // one quotient bit per cycle, remainder stays below the divisor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      den_q <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      quot  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem   <= num;
        den_q <= den;
        cnt   <= CNT_W'(FRAC_W);
        busy  <= 1'b1;
        quot  <= '0;
      end else if (busy) begin
        rem  <= take ? NW'(diff) : NW'(shifted);
        quot <= {quot[FRAC_W-2:0], take};
        cnt  <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // the interpolation span must exceed the offset so the fraction fits
  assert_start_ordered_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> num < den);

  assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rem < den_q);

endmodule

// File: rtl/cfd_timing_top.sv
module cfd_timing_top #(
  parameter int SAMPLE_W = 12,
  parameter int DEPTH    = 64,
  parameter int K_W      = 8,
  parameter int FRAC_W   = 8,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW      = SAMPLE_W + 1,
  localparam int NW      = CW + 1,
  localparam int TW      = IDX_W + FRAC_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_data,
  input  logic                       in_first,
  input  logic                       in_last,
  input  logic [K_W-1:0]             k_frac,
  input  logic                       invert,
  input  logic signed [SAMPLE_W-1:0] baseline,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic                       out_hit,
  output logic [TW-1:0]              out_time,
  output logic signed [CW-1:0]       out_amp
);
  import cfd_pkg::*;

  cfd_state_e state;

  logic [K_W-1:0]             k_q;
  logic                       inv_q;
  logic signed [SAMPLE_W-1:0] base_q;

  logic                       wr_en, wr_first, close_evt;
  logic                       win_inv;
  logic signed [SAMPLE_W-1:0] win_base;
  logic [IDX_W-1:0]           rd_idx, peak_idx, wr_pos;
  logic signed [CW-1:0]       rd_data, peak;

  logic [IDX_W-1:0]           scan_idx, cross_idx;
  logic signed [CW-1:0]       thr_q, hi_q, thr_next;
  logic [CW+K_W-1:0]          prod;
  logic signed [CW:0]         num_s, den_s;
  logic                       below, peak_bad;
  logic                       div_start, div_busy, div_done;
  logic [FRAC_W-1:0]          div_quot;

  assign in_ready  = (state == ST_IDLE) || (state == ST_CAP);
  assign out_valid = (state == ST_OUT);
  assign out_amp   = peak;

  // in idle only a start-marked sample opens an event; others are dropped
  assign wr_first  = (state == ST_IDLE);
  assign wr_en     = in_valid && in_ready && (in_first || state == ST_CAP);
  assign close_evt = in_last || (state == ST_CAP && wr_pos == IDX_W'(DEPTH - 1));
  assign win_inv   = wr_first ? invert   : inv_q;
  assign win_base  = wr_first ? baseline : base_q;

  cfd_window #(
    .SAMPLE_W (SAMPLE_W),
    .DEPTH    (DEPTH)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_first  (wr_first),
    .wr_sample (in_data),
    .baseline  (win_base),
    .invert    (win_inv),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .peak      (peak),
    .peak_idx  (peak_idx),
    .wr_pos    (wr_pos)
  );

  // threshold: peak scaled by k / 2^K_W, only used when peak is positive
  assign prod     = $unsigned(peak) * k_q;
  assign thr_next = CW'(prod >> K_W);
  assign peak_bad = peak[CW-1] || (peak == '0);

  assign rd_idx    = scan_idx - IDX_W'(1);
  assign below     = rd_data <= thr_q;
  assign num_s     = {thr_q[CW-1], thr_q} - {rd_data[CW-1], rd_data};
  assign den_s     = {hi_q[CW-1], hi_q} - {rd_data[CW-1], rd_data};
  assign div_start = (state == ST_SCAN) && (scan_idx != '0) && below;

  cfd_frac_div #(
    .NW     (NW),
    .FRAC_W (FRAC_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   ($unsigned(num_s)),
    .den   ($unsigned(den_s)),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (div_quot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      k_q       <= '0;
      inv_q     <= 1'b0;
      base_q    <= '0;
      scan_idx  <= '0;
      cross_idx <= '0;
      thr_q     <= '0;
      hi_q      <= '0;
      out_hit   <= 1'b0;
      out_time  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (wr_en) begin
            k_q    <= k_frac;
            inv_q  <= invert;
            base_q <= baseline;
            state  <= in_last ? ST_THR : ST_CAP;
          end
        end
        ST_CAP: begin
          if (wr_en && close_evt) state <= ST_THR;
        end
        ST_THR: begin
          if (peak_bad) begin
            out_hit  <= 1'b0;
            out_time <= '0;
            state    <= ST_OUT;
          end else begin
            thr_q    <= thr_next;
            hi_q     <= peak;
            scan_idx <= peak_idx;
            state    <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (scan_idx == '0) begin
            out_hit  <= 1'b0;
            out_time <= '0;
            state    <= ST_OUT;
          end else if (below) begin
            cross_idx <= rd_idx;
            state     <= ST_DIV;
          end else begin
            hi_q     <= rd_data;
            scan_idx <= rd_idx;
          end
        end
        ST_DIV: begin
          if (div_done) begin
            out_hit  <= 1'b1;
            out_time <= {cross_idx, div_quot};
            state    <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_time) && $stable(out_hit) && $stable(out_amp));

  assert_no_accept_while_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_hit_has_amp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> !out_amp[CW-1] && out_amp != '0);

  assert_cross_before_peak_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> out_time[TW-1:FRAC_W] < peak_idx);

  assert_div_only_in_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> state == ST_DIV);

endmodule

// File: tb/cfd_timing_top_test.sv
`timescale 1ns/1ps
module cfd_timing_top_test;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [11:0] in_data = '0;
  logic               in_first = 1'b0;
  logic               in_last = 1'b0;
  logic [7:0]         k_frac = '0;
  logic               invert = 1'b0;
  logic signed [11:0] baseline = '0;
  logic               out_valid;
  logic               out_ready = 1'b0;
  logic               out_hit;
  logic [13:0]        out_time;
  logic signed [12:0] out_amp;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit stall_mode = 1'b0;

  int    ev[$];
  int    exp_hit[$];
  int    exp_time[$];
  int    exp_amp[$];
  string exp_tag[$];
  int    got_time[$];

  bit pend = 1'b0;
  int pend_hit, pend_time, pend_amp;

  always #10 clk = ~clk;

  cfd_timing_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last), .k_frac(k_frac),
    .invert(invert), .baseline(baseline), .out_valid(out_valid), .out_ready(out_ready),
    .out_hit(out_hit), .out_time(out_time), .out_amp(out_amp)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // reference model of one event from the raw samples in ev
  function automatic void model(input int n, input int k, input int inv, input int base, input string tag);
    int c[$];
    int pk, pi, thr, t;
    bit hit;
    for (int i = 0; i < n; i++) c.push_back(inv != 0 ? base - ev[i] : ev[i] - base);
    pk = c[0];
    pi = 0;
    for (int i = 1; i < n; i++) if (c[i] > pk) begin pk = c[i]; pi = i; end
    hit = 1'b0;
    t = 0;
    if (pk > 0) begin
      thr = (pk * k) / 256;
      for (int j = pi - 1; j >= 0; j--) begin
        if (!hit && c[j] <= thr) begin
          t = j * 256 + ((thr - c[j]) * 256) / (c[j + 1] - c[j]);
          hit = 1'b1;
        end
      end
    end
    exp_hit.push_back(int'(hit));
    exp_time.push_back(t);
    exp_amp.push_back(pk);
    exp_tag.push_back(tag);
  endfunction

  task automatic push(input int v, input bit f, input bit l, input int k, input int inv, input int base);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 12'(v);
    in_first = f;
    in_last  = l;
    k_frac   = 8'(k);
    invert   = 1'(inv);
    baseline = 12'(base);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // sends ev as one event; samples after the first carry the k2/base2 settings
  task automatic send_event(input int k, input int inv, input int base, input int k2,
                            input int base2, input string tag);
    int n;
    n = (ev.size() > 64) ? 64 : ev.size();
    model(n, k, inv, base, tag);
    for (int i = 0; i < ev.size(); i++)
      push(ev[i], i == 0, i == ev.size() - 1, (i == 0) ? k : k2, inv, (i == 0) ? base : base2);
  endtask

  task automatic drain;
    int guard;
    guard = 0;
    while (exp_time.size() != 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(exp_time.size() == 0, "R9 result delivery", exp_time.size(), 0);
  endtask

  // consumer and per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (pend) begin
        check(out_valid && int'(out_hit) == pend_hit && int'(out_time) == pend_time &&
              int'(out_amp) == pend_amp, "R9 hold under stall", int'(out_time), pend_time);
      end
      if (out_valid && in_ready) check(1'b0, "R9 ready while result pending", 1, 0);
      out_ready = !stall_mode || (cyc % 4 == 3);
      if (out_valid && out_ready) begin
        if (exp_time.size() == 0) begin
          check(1'b0, "R7 unexpected result", int'(out_time), -1);
        end else begin
          string tg;
          int eh, et, ea;
          tg = exp_tag.pop_front();
          eh = exp_hit.pop_front();
          et = exp_time.pop_front();
          ea = exp_amp.pop_front();
          check(int'(out_hit) == eh, {tg, " hit"}, int'(out_hit), eh);
          check(int'(out_time) == et, {tg, " time"}, int'(out_time), et);
          check(int'(out_amp) == ea, {tg, " amp"}, int'(out_amp), ea);
          got_time.push_back(int'(out_time));
        end
      end
      pend = out_valid && !out_ready;
      pend_hit = int'(out_hit);
      pend_time = int'(out_time);
      pend_amp = int'(out_amp);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(in_ready == 1'b1, "R11 in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R11 out_valid after reset", int'(out_valid), 0);
    rst_n = 1'b1;

    // R1 R3 R4 basic positive pulse
    ev = '{0, 0, 10, 40, 100, 60, 20, 0};
    send_event(128, 0, 0, 128, 0, "R3 basic pulse");
    // R5 same shape at twice the height
    ev = '{0, 0, 20, 80, 200, 120, 40, 0};
    send_event(128, 0, 0, 128, 0, "R5 scaled pulse");
    drain();
    check(got_time.size() >= 2 && got_time[0] == got_time[1], "R5 time independent of height",
          got_time.size() >= 2 ? got_time[1] : -1, got_time.size() >= 1 ? got_time[0] : -1);

    // R1 negative pulse on a raised pedestal
    ev = '{100, 100, 90, 60, 0, 40, 80, 100};
    send_event(128, 1, 100, 128, 100, "R1 negative pulse");

    // R4 sample exactly on threshold
    ev = '{0, 50, 100};
    send_event(128, 0, 0, 128, 0, "R4 equal to threshold");

    // R2 tied maxima, first one wins
    ev = '{0, 80, 20, 80, 0};
    send_event(128, 0, 0, 128, 0, "R2 tied peaks");

    // R2 extreme fractions
    ev = '{0, 5, 10, 5};
    send_event(0, 0, 0, 0, 0, "R2 zero fraction");
    ev = '{0, 100, 200};
    send_event(255, 0, 0, 255, 0, "R2 full fraction");

    // R6 peak in first slot, and no positive excursion
    ev = '{100, 50, 0};
    send_event(128, 0, 0, 128, 0, "R6 peak at start");
    ev = '{-5, -3, -9};
    send_event(128, 0, 0, 128, 0, "R6 no positive peak");
    ev = '{77};
    send_event(128, 0, 0, 128, 0, "R6 single sample");
    drain();

    // R7 stray samples before an event are dropped
    push(900, 1'b0, 1'b0, 128, 0, 0);
    push(1500, 1'b0, 1'b1, 128, 0, 0);
    ev = '{0, 30, 90, 30};
    send_event(128, 0, 0, 128, 0, "R7 after stray samples");

    // R9 stalled consumer
    stall_mode = 1'b1;
    ev = '{0, 10, 60, 120, 60};
    send_event(64, 0, 0, 64, 0, "R9 stalled result a");
    ev = '{-2, 4, 30, 90, 150, 20};
    send_event(200, 0, -2, 200, -2, "R9 stalled result b");
    drain();
    stall_mode = 1'b0;

    // R10 configuration changes mid-event are ignored
    ev = '{10, 10, 40, 70, 130, 70};
    send_event(128, 0, 10, 32, 50, "R10 config held");

    // R8 event longer than the window
    ev.delete();
    for (int i = 0; i < 70; i++) ev.push_back(i == 20 ? 200 : (i == 66 ? 1000 : 0));
    send_event(128, 0, 0, 128, 0, "R8 window limit");
    ev = '{0, 40, 160, 20};
    send_event(128, 0, 0, 128, 0, "R8 next event after overflow");
    drain();

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule